// File: doc/BRIEF.md
# Serial Configuration Memory Read Responder

This block stands in for a small three-wire serial configuration memory that a network controller reads at power-up. The controller drives a serial clock; the responder watches that clock, which is asynchronous to the system clock, and answers on one data line. The answer is a fixed nine-word image, taken in order. The responder does not decode the command or address the controller sends. For every word it counts an exact number of serial clock cycles: a silent preamble, sixteen data bits, and a silent tail.

An arm input enables the responder. While it is low, the data line is released and all counting is held at the start. Once the ninth word is complete, a done flag rises and the line is released until the block is disarmed and armed again. Release is shown on `sdo_oe`. A pad cell outside the block turns it into a high-impedance state.

Top module: `cfg_rom_responder`

## Requirements
- R1: `sdo_oe` is high only while `arm` is high and `done` is low; at reset it is low, and whenever `sdo_oe` is low `sdo` reads 0.
- R2: The first 11 serial clock cycles of every word are a preamble during which `sdo` stays 0.
- R3: Serial clock cycles 12 to 27 of a word carry 16 data bits, most significant first; the image byte with the lower index is sent first, with each byte MSB first.
- R4: Each data bit appears on `sdo` after a rising serial clock edge and is forced to 0 after the following falling edge.
- R5: After the 16 data bits, 5 tail cycles pass with `sdo` at 0, and then the next word's preamble starts.
- R6: The image is 18 bytes: byte index 3 is 0x30 and every other byte is 0xFF. Word 1 is therefore 0xFF30 and the other eight words are 0xFFFF.
- R7: `done` rises after the falling edge that ends the tail of the ninth word; after that, `sdo_oe` stays low and further serial clocks have no effect while `arm` stays high.
- R8: Dropping `arm` at any point clears `done` and resets the word and cycle position, so the next arming starts again at word 0, cycle 0.
- R9: The serial clock passes through a two-flop synchronizer, so `sdo` changes on the third system clock edge after a serial clock edge. Serial clock edges seen while disarmed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables responding; low releases the line and resets the position |
| sclk_in | input | 1 | Serial clock from the reading device, asynchronous |
| sdo | output | 1 | Serial data toward the reader |
| sdo_oe | output | 1 | High while the block drives `sdo`; low means released |
| done | output | 1 | High once the whole image has been delivered |

## Verification
A serial clock edge at the input reaches `sdo` on the third rising system clock edge: two synchronizer stages, then the output flop. `done` follows the last falling serial edge with the same three-edge delay. The bench holds each half of the serial clock for eight system cycles and samples six falling system edges after each change, which is well inside the settled window. For the first data bit it also samples at the second and third falling edges, to pin the latency exactly. Expected bits come from a byte-indexed model of the image, independent of the design's word packing. The scoreboard pairs them with each sample in order.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // byte of the fixed image at a given index
  function automatic logic [BYTE_W-1:0] image_byte(input int unsigned idx,
                                                   input int unsigned sp_idx,
                                                   input logic [BYTE_W-1:0] sp_val,
                                                   input logic [BYTE_W-1:0] fill);
    return (idx == sp_idx) ? sp_val : fill;
  endfunction

  // word w: lower-indexed byte occupies the upper half (sent first)
  function automatic logic [WORD_W-1:0] image_word(input int unsigned w,
                                                   input int unsigned sp_idx,
                                                   input logic [BYTE_W-1:0] sp_val,
                                                   input logic [BYTE_W-1:0] fill);
    return {image_byte(2 * w, sp_idx, sp_val, fill),
            image_byte(2 * w + 1, sp_idx, sp_val, fill)};
  endfunction

  // bit at serial position pos, position 0 being the word MSB
  function automatic logic pick_bit(input logic [WORD_W-1:0] word,
                                    input logic [3:0] pos);
    return word[4'd15 - pos];
  endfunction
endpackage

// File: rtl/rsp_sync_edge.sv
module rsp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_ev = sync_q[STAGES-1] & ~prev_q;
  assign fall_ev = ~sync_q[STAGES-1] & prev_q;

  // R9
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));
endmodule

// File: rtl/rsp_frame_seq.sv
module rsp_frame_seq #(
  parameter int PRE_CYC   = 11,
  parameter int DATA_CYC  = 16,
  parameter int POST_CYC  = 5,
  parameter int NUM_WORDS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 fall_ev,
  output logic [$clog2(NUM_WORDS)-1:0] word_q,
  output logic [3:0]           bit_idx,
  output logic                 in_pre,
  output logic                 in_data,
  output logic                 word_done_ev,
  output logic                 done_q
);
  localparam int TOTAL = PRE_CYC + DATA_CYC + POST_CYC;
  localparam int CW    = $clog2(TOTAL);
  localparam int WW    = $clog2(NUM_WORDS);
  localparam logic [CW-1:0] LAST_C     = CW'(TOTAL - 1);
  localparam logic [CW-1:0] PRE_C      = CW'(PRE_CYC);
  localparam logic [CW-1:0] DATA_END_C = CW'(PRE_CYC + DATA_CYC);
  localparam logic [WW-1:0] LAST_W     = WW'(NUM_WORDS - 1);

  logic [CW-1:0] cyc_q;
  logic          last_cyc;
  logic          counting;

  assign last_cyc     = (cyc_q == LAST_C);
  assign in_pre       = (cyc_q < PRE_C);
  assign in_data      = (cyc_q >= PRE_C) && (cyc_q < DATA_END_C);
  assign bit_idx      = 4'(cyc_q - PRE_C);
  assign counting     = arm && !done_q;
  assign word_done_ev = counting && fall_ev && last_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      cyc_q  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else if (counting && fall_ev) begin
      if (last_cyc) begin
        cyc_q <= '0;
        if (word_q == LAST_W) begin
          word_q <= '0;
          done_q <= 1'b1;
        end else begin
          word_q <= word_q + 1'b1;
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // R5
  tail_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_ev |=> (cyc_q == '0));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && arm) |=> done_q);
  // R8
  disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!done_q && word_q == '0 && cyc_q == '0));
endmodule

// File: rtl/rsp_bit_drive.sv
module rsp_bit_drive
  import rsp_pkg::*;
#(
  parameter int          NUM_WORDS   = 9,
  parameter int          SPECIAL_IDX = 3,
  parameter logic [7:0]  SPECIAL_VAL = 8'h30,
  parameter logic [7:0]  FILL_VAL    = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 in_pre,
  input  logic                 in_data,
  input  logic [$clog2(NUM_WORDS)-1:0] word_q,
  input  logic [3:0]           bit_idx,
  output logic                 sdo_q
);
  logic [WORD_W-1:0] cur_word;

  assign cur_word = image_word(32'(word_q), SPECIAL_IDX, SPECIAL_VAL, FILL_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n || !active || fall_ev) sdo_q <= 1'b0;
    else if (rise_ev && in_data)      sdo_q <= pick_bit(cur_word, bit_idx);
  end

  // R4
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_q) |-> $past(rise_ev));
  // R4
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !sdo_q);
  // R2
  pre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && in_pre) |=> !sdo_q);
endmodule

// File: rtl/cfg_rom_responder.sv
module cfg_rom_responder #(
  parameter int         SYNC_STAGES = 2,
  parameter int         PRE_CYC     = 11,
  parameter int         POST_CYC    = 5,
  parameter int         NUM_WORDS   = 9,
  parameter int         SPECIAL_IDX = 3,
  parameter logic [7:0] SPECIAL_VAL = 8'h30,
  parameter logic [7:0] FILL_VAL    = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sclk_in,
  output logic sdo,
  output logic sdo_oe,
  output logic done
);
  localparam int WW = $clog2(NUM_WORDS);

  logic          rise_ev, fall_ev;
  logic [WW-1:0] word_q;
  logic [3:0]    bit_idx;
  logic          in_pre, in_data, word_done_ev, done_q, active, sdo_q;

  rsp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev));

  rsp_frame_seq #(.PRE_CYC(PRE_CYC), .DATA_CYC(rsp_pkg::WORD_W),
                  .POST_CYC(POST_CYC), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .fall_ev(fall_ev),
    .word_q(word_q), .bit_idx(bit_idx), .in_pre(in_pre), .in_data(in_data),
    .word_done_ev(word_done_ev), .done_q(done_q));

  assign active = arm && !done_q;

  rsp_bit_drive #(.NUM_WORDS(NUM_WORDS), .SPECIAL_IDX(SPECIAL_IDX),
                  .SPECIAL_VAL(SPECIAL_VAL), .FILL_VAL(FILL_VAL)) u_drv (
    .clk(clk), .rst_n(rst_n), .active(active), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .in_pre(in_pre), .in_data(in_data),
    .word_q(word_q), .bit_idx(bit_idx), .sdo_q(sdo_q));

  assign sdo_oe = active;
  assign sdo    = sdo_q & active;
  assign done   = done_q;

  // R7
  done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(word_done_ev));
  // R1
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

// File: tb/test_cfg_rom_responder.sv
module test_cfg_rom_responder;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 11;
  localparam int DAT = 16;
  localparam int TOT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic sclk_in = 1'b0;
  logic sdo, sdo_oe, done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;

  cfg_rom_responder i_cfg_rom_responder (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sclk_in(sclk_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // byte model of the image (R6)
  function automatic logic [7:0] img_byte(input int i);
    return (i == 3) ? 8'h30 : 8'hFF;
  endfunction

  function automatic logic exp_bit(input int w, input int c);
    int k;
    logic [7:0] b;
    if (c < PRE || c >= PRE + DAT) return 1'b0;
    k = c - PRE;
    b = (k < 8) ? img_byte(2 * w) : img_byte(2 * w + 1);
    return b[7 - (k % 8)];
  endfunction

  // monitor: pops expected (oe, sdo) pairs at each sample point
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", 8'd1, 8'd0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {6'd0, sdo_oe, sdo}, {6'd0, e});
      end
    end
  end

  // one serial clock cycle; pushes expected values for both halves
  task automatic sclk_cycle(input logic hi_oe, input logic hi_bit, input string hi_tag,
                            input logic lo_oe, input string lo_tag, input bit lat_chk);
    exp_q.push_back({hi_oe, hi_bit}); tag_q.push_back(hi_tag);
    sclk_in = 1'b1;
    if (lat_chk) begin
      repeat (2) @(negedge clk);
      check("R9 latency early", {7'd0, sdo}, 8'd0);
      @(negedge clk);
      check("R9 latency due", {7'd0, sdo}, {7'd0, hi_bit});
      repeat (3) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    -> smp_ev;
    repeat (2) @(negedge clk);
    exp_q.push_back({lo_oe, 1'b0}); tag_q.push_back(lo_tag);
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    -> smp_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic stream_word(input int w, input int ncyc, input string over, input bit last);
    for (int c = 0; c < ncyc; c++) begin
      string t;
      if (over.len() != 0) t = over;
      else if (c < PRE) t = "R2";
      else if (c < PRE + DAT) t = (w == 1) ? "R6" : "R3";
      else t = "R5";
      sclk_cycle(1'b1, exp_bit(w, c), t,
                 !(last && c == TOT - 1), (last && c == TOT - 1) ? "R7" : "R4",
                 (w == 0 && c == PRE && over.len() == 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset oe", {7'd0, sdo_oe}, 8'd0);
    check("R1 reset sdo", {7'd0, sdo}, 8'd0);
    check("R7 reset done", {7'd0, done}, 8'd0);

    // disarmed: clocks ignored, line released (R9, R1)
    for (int i = 0; i < 3; i++) sclk_cycle(1'b0, 1'b0, "R9", 1'b0, "R1", 1'b0);

    arm = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 armed oe", {7'd0, sdo_oe}, 8'd1);
    for (int w = 0; w < 9; w++) stream_word(w, TOT, "", w == 8);
    check("R7 done raised", {7'd0, done}, 8'd1);
    for (int i = 0; i < 2; i++) sclk_cycle(1'b0, 1'b0, "R7", 1'b0, "R7", 1'b0);
    check("R7 done held", {7'd0, done}, 8'd1);

    // R8: disarm clears, mid-transfer drop restarts at word 0
    arm = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 done cleared", {7'd0, done}, 8'd0);
    arm = 1'b1;
    repeat (3) @(negedge clk);
    stream_word(0, TOT, "", 1'b0);
    stream_word(1, 15, "", 1'b0);
    arm = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 disarm releases", {7'd0, sdo_oe}, 8'd0);
    arm = 1'b1;
    repeat (3) @(negedge clk);
    stream_word(0, TOT, "R8", 1'b0);
    stream_word(1, TOT, "R8", 1'b0);
    check("R8 not done", {7'd0, done}, 8'd0);

    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size() == 0 ? 8'd1 : 8'd0, 8'd1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule